// File: doc/BRIEF.md
# Write-Once Byte Store with EPROM-Style Control

This block is a synthesizable stand-in for an ultraviolet-erasable, write-once byte memory, driven through the classic active-low control trio: chip select, output gate and program strobe. Two boolean qualifiers stand in for the analog levels. One says the programming supply is at its high level. The other says address bit 9 is held at the high identification level. From these inputs the block decodes one operating mode per clock. The modes are read, identification read, program, program verify, output disable, standby and program inhibit.

Programming works like a fuse array. A blank word is all ones, and a program cycle can only clear bits, so the stored word becomes the old word ANDed with the input byte. A separate erase request stands in for the ultraviolet exposure. It sweeps the whole array back to all ones, one word per clock. Program requests that arrive during the sweep are dropped. The data bus is split into an input byte, an output byte and an output drive flag. Both outputs are registered, so they follow the control inputs one clock later.

The depth is 2^ADDR_W words. ADDR_W = 14 gives the full 16K x 8 organisation. The default is smaller so that the model stays light.

Top module: `otp_store_emu`

## Requirements
- R1: While reset is applied and after it is released, with no access requested, `rd_drive` is 0 and `erase_busy` is 0.
- R2: With `chip_en_n`=0, `out_en_n`=0, `prog_hv`=0 and `idsel_hv`=0 at a clock edge, `rd_drive` is 1 after that edge and `rd_data` holds the word stored at `addr`.
- R3: With `chip_en_n`=1, `rd_drive` is 0 after the edge whatever `out_en_n` is. If `prog_hv`=1 at the same time (inhibit), no word is written even with `prog_en_n`=0.
- R4: With `chip_en_n`=0, `out_en_n`=1 and no program request, `rd_drive` is 0 after the edge.
- R5: With `prog_hv`=1, `chip_en_n`=0 and `prog_en_n`=0 (program), the word at `addr` becomes old AND `wr_data`, and `rd_drive` is 0 after the edge.
- R6: With `prog_hv`=1, `chip_en_n`=0, `out_en_n`=0 and `prog_en_n`=1 (verify), `rd_drive` is 1 and `rd_data` holds the stored word, including a write made on the previous clock.
- R7: In a read with `idsel_hv`=1, `rd_data` is 8'h01 when `addr[0]`=0 and 8'h16 when `addr[0]`=1. In both codes bit 7 makes the byte's parity odd.
- R8: A one-clock `erase_start` while idle raises `erase_busy` for exactly 2^ADDR_W clocks. Afterwards every word reads 8'hFF.
- R9: A program request made while `erase_busy` is 1 changes no word.
- R10: `rd_drive` and `rd_data` change only on the clock edge after the control inputs change. Between edges they keep their earlier values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| chip_en_n | input | 1 | Device select, active low |
| out_en_n | input | 1 | Output gate, active low |
| prog_en_n | input | 1 | Program strobe, active low |
| prog_hv | input | 1 | Programming supply at its high level |
| idsel_hv | input | 1 | Address bit 9 at the identification level |
| addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Byte to program |
| erase_start | input | 1 | Start a full-array erase sweep |
| rd_data | output | DATA_W | Registered read byte |
| rd_drive | output | 1 | Registered bus drive enable |
| erase_busy | output | 1 | Erase sweep in progress |

## Verification
Assertions check four things on every clock. Standby, output disable and program cycles must leave the bus undriven on the next cycle. Every driven identification byte must have odd parity. An erase sweep must last exactly the array depth. A program request during a sweep must leave its target word untouched. Other behaviour shows only in the bench's scenarios against its shadow array. These include the AND-only accumulation across repeated programs and the verify read-back of a word written on the previous clock. They also include the exact identification values, the inhibit case that leaves the array unchanged, and the one-clock output latency.

// File: rtl/otpe_pkg.sv
`timescale 1ns/1ps
package otpe_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY = 3'd0,
    MD_INHIBIT = 3'd1,
    MD_PROGRAM = 3'd2,
    MD_VERIFY  = 3'd3,
    MD_READ    = 3'd4,
    MD_IDREAD  = 3'd5,
    MD_OUTOFF  = 3'd6
  } otpe_mode_e;

  function automatic logic mode_drives(input otpe_mode_e m);
    return (m == MD_READ) || (m == MD_VERIFY) || (m == MD_IDREAD);
  endfunction

endpackage

// File: rtl/otpe_mode_decode.sv
`timescale 1ns/1ps
module otpe_mode_decode
  import otpe_pkg::*;
(
  input  logic       chip_en_n,
  input  logic       out_en_n,
  input  logic       prog_en_n,
  input  logic       prog_hv,
  input  logic       idsel_hv,
  output otpe_mode_e mode
);

  always_comb begin
    if (chip_en_n) begin
      mode = prog_hv ? MD_INHIBIT : MD_STANDBY;
    end else if (prog_hv && !prog_en_n) begin
      mode = MD_PROGRAM;
    end else if (out_en_n) begin
      mode = MD_OUTOFF;
    end else if (prog_hv) begin
      mode = MD_VERIFY;
    end else if (idsel_hv) begin
      mode = MD_IDREAD;
    end else begin
      mode = MD_READ;
    end
  end

endmodule

// File: rtl/otpe_id_codes.sv
`timescale 1ns/1ps
module otpe_id_codes #(
  parameter int               DATA_W    = 8,
  parameter logic [DATA_W-2:0] MAKER_LO = 7'h01,
  parameter logic [DATA_W-2:0] PART_LO  = 7'h16
) (
  input  logic              sel_part,
  output logic [DATA_W-1:0] id_byte
);

  localparam int NCODES = 2;

  logic [DATA_W-1:0] codes [NCODES];

  // Each code gets a top bit that forces odd parity over the whole byte.
  for (genvar g = 0; g < NCODES; g++) begin : g_code
    localparam logic [DATA_W-2:0] LO = (g == 0) ? MAKER_LO : PART_LO;
    assign codes[g] = {~^LO, LO};
  end

  assign id_byte = sel_part ? codes[1] : codes[0];

endmodule

// File: rtl/otpe_array.sv
`timescale 1ns/1ps
module otpe_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] prog_byte,
  input  logic              erase_start,
  output logic [DATA_W-1:0] rd_word,
  output logic              busy
);

  localparam int          DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];

  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] sweep_q, sweep_d;
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;

  assign rd_word = mem[addr];
  assign busy    = busy_q;

  // Sweep sequencing
  always_comb begin
    busy_d  = busy_q;
    sweep_d = sweep_q;
    if (busy_q) begin
      sweep_d = sweep_q + 1'b1;
      if (sweep_q == LAST) busy_d = 1'b0;
    end else if (erase_start) begin
      busy_d  = 1'b1;
      sweep_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sweep_q <= '0;
    end else begin
      busy_q  <= busy_d;
      sweep_q <= sweep_d;
    end
  end

  // Write port: the sweep owns the array while busy; programming only clears bits
  always_comb begin
    if (busy_q) begin
      we    = 1'b1;
      waddr = sweep_q;
      wdata = '1;
    end else begin
      we    = prog_req;
      waddr = addr;
      wdata = mem[addr] & prog_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Checker: run length of the busy window
  logic [ADDR_W:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_q) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R8: the sweep never outlasts the array depth
  a_r8_sweep_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (run_q < (ADDR_W+1)'(DEPTH)));

  // R8: when the sweep ends, it has lasted exactly the array depth
  a_r8_sweep_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (run_q == (ADDR_W+1)'(DEPTH)));

  // R9: a program request during the sweep leaves its target word alone
  a_r9_prog_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && prog_req && (addr != sweep_q)) |=> (mem[$past(addr)] == $past(rd_word)));

endmodule

// File: rtl/otp_store_emu.sv
`timescale 1ns/1ps
module otp_store_emu
  import otpe_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en_n,
  input  logic              out_en_n,
  input  logic              prog_en_n,
  input  logic              prog_hv,
  input  logic              idsel_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              erase_start,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive,
  output logic              erase_busy
);

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  otpe_mode_e        mode;
  logic [DATA_W-1:0] id_byte;
  logic [DATA_W-1:0] arr_word;

  otpe_mode_decode u_decode (
    .chip_en_n (chip_en_n),
    .out_en_n  (out_en_n),
    .prog_en_n (prog_en_n),
    .prog_hv   (prog_hv),
    .idsel_hv  (idsel_hv),
    .mode      (mode)
  );

  otpe_id_codes #(.DATA_W(DATA_W)) u_id (
    .sel_part (addr[0]),
    .id_byte  (id_byte)
  );

  otpe_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .prog_req    (mode == MD_PROGRAM),
    .addr        (addr),
    .prog_byte   (wr_data),
    .erase_start (erase_start),
    .rd_word     (arr_word),
    .busy        (erase_busy)
  );

  // Output registers: next-state, then register with explicit enable
  logic              drive_d, drive_q;
  logic              data_en;
  logic [DATA_W-1:0] data_d, data_q;

  always_comb begin
    drive_d = mode_drives(mode);
    data_en = drive_d;
    data_d  = (mode == MD_IDREAD) ? id_byte : arr_word;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      drive_q <= 1'b0;
      data_q  <= '0;
    end else begin
      drive_q <= drive_d;
      if (data_en) data_q <= data_d;
    end
  end

  assign rd_drive = drive_q;
  assign rd_data  = data_q;

  // R3: standby or inhibit leaves the bus undriven on the next cycle
  a_r3_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_int_n)
    chip_en_n |=> !rd_drive);

  // R4: output gate high and no program request leaves the bus undriven
  a_r4_outoff_hiz: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!chip_en_n && out_en_n && !(prog_hv && !prog_en_n)) |=> !rd_drive);

  // R5: a program cycle never drives the bus
  a_r5_program_hiz: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!chip_en_n && prog_hv && !prog_en_n) |=> !rd_drive);

  // R7: a driven identification byte has odd parity
  a_r7_id_parity: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!chip_en_n && !out_en_n && !prog_hv && idsel_hv) |=> (rd_drive && (^rd_data)));

endmodule

// File: tb/otp_store_emu_tb_top.sv
`timescale 1ns/1ps
module otp_store_emu_tb_top;

  localparam int AW    = 11;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, pg_n, hv, idh, er;
  logic [AW-1:0] a;
  logic [DW-1:0] d;
  logic [DW-1:0] rd_data;
  logic          rd_drive, erase_busy;

  always #2 clk = ~clk;

  otp_store_emu #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .chip_en_n (ce_n), .out_en_n (oe_n), .prog_en_n (pg_n),
    .prog_hv (hv), .idsel_hv (idh), .addr (a), .wr_data (d),
    .erase_start (er), .rd_data (rd_data), .rd_drive (rd_drive),
    .erase_busy (erase_busy)
  );

  typedef struct {
    logic          chk;
    logic          drv;
    logic [DW-1:0] val;
    string         tag;
  } exp_t;

  exp_t          sb_q[$];
  int            n_run  = 0;
  int            n_fail = 0;
  logic [DW-1:0] model [DEPTH];

  task automatic check(input logic ok, input string tag, input string act, input string exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %s expected %s", tag, act, exp);
    end
  endtask

  // Monitor: one expected item per clock edge, sampled just after the edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      if (it.chk) begin
        check((rd_drive === it.drv) && (!it.drv || rd_data === it.val), it.tag,
              $sformatf("drive=%b data=%02h", rd_drive, rd_data),
              $sformatf("drive=%b data=%02h", it.drv, it.val));
      end
    end
  end

  // Driver: apply controls at the falling edge and queue the expectation
  task automatic drive(input logic c, input logic o, input logic p, input logic h,
                       input logic i, input logic [AW-1:0] ad, input logic [DW-1:0] dt,
                       input logic e, input logic chk, input logic ed,
                       input logic [DW-1:0] ev, input string tag);
    exp_t it;
    @(negedge clk);
    ce_n = c; oe_n = o; pg_n = p; hv = h; idh = i; a = ad; d = dt; er = e;
    it.chk = chk; it.drv = ed; it.val = ev; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk);
  endtask

  task automatic idle();
    drive(1, 1, 1, 0, 0, '0, '0, 0, 0, 0, '0, "idle");
  endtask

  task automatic rd(input logic [AW-1:0] ad, input string tag);
    drive(0, 0, 1, 0, 0, ad, '0, 0, 1, 1, model[ad], tag);
  endtask

  task automatic prog(input logic [AW-1:0] ad, input logic [DW-1:0] dt, input string tag);
    drive(0, 1, 0, 1, 0, ad, dt, 0, 1, 0, '0, tag);
    model[ad] = model[ad] & dt;
  endtask

  task automatic verify(input logic [AW-1:0] ad, input string tag);
    drive(0, 0, 1, 1, 0, ad, '0, 0, 1, 1, model[ad], tag);
  endtask

  task automatic erase_and_count(output int cycles);
    drive(1, 1, 1, 0, 0, '0, '0, 1, 0, 0, '0, "erase");
    @(negedge clk);
    er = 1'b0;
    cycles = 0;
    while (erase_busy === 1'b1 && cycles < DEPTH + 10) begin
      @(posedge clk); #1;
      cycles++;
    end
    for (int k = 0; k < DEPTH; k++) model[k] = '1;
  endtask

  initial begin
    int cyc;
    rst_n = 1'b0;
    ce_n = 1; oe_n = 1; pg_n = 1; hv = 0; idh = 0; er = 0; a = '0; d = '0;
    repeat (4) @(posedge clk);
    #1;
    check(rd_drive === 1'b0 && erase_busy === 1'b0, "R1 in reset",
          $sformatf("%b%b", rd_drive, erase_busy), "00");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(rd_drive === 1'b0 && erase_busy === 1'b0, "R1 after reset",
          $sformatf("%b%b", rd_drive, erase_busy), "00");

    // R8: erase sweep length and blank contents
    erase_and_count(cyc);
    check(cyc == DEPTH, "R8 busy length", $sformatf("%0d", cyc), $sformatf("%0d", DEPTH));
    rd(11'd0, "R8 blank word 0");
    rd(11'(DEPTH - 1), "R8 blank last word");

    // R2/R5/R6: program, accumulate with AND, verify and read
    prog(11'd5, 8'hA5, "R5 program no drive");
    verify(11'd5, "R6 verify after program");
    prog(11'd5, 8'h0F, "R5 second program");
    rd(11'd5, "R5 AND accumulation");
    prog(11'd300, 8'h3C, "R5 program other word");
    rd(11'd300, "R2 read programmed word");
    rd(11'd301, "R2 neighbour untouched");

    // R10: outputs hold until the next edge
    rd(11'd5, "R10 setup read");
    @(negedge clk);
    oe_n = 1'b1;
    #1;
    check(rd_drive === 1'b1 && rd_data === model[5], "R10 holds before edge",
          $sformatf("%b %02h", rd_drive, rd_data), $sformatf("1 %02h", model[5]));
    @(posedge clk); #1;
    check(rd_drive === 1'b0, "R10 R4 drops after edge", $sformatf("%b", rd_drive), "0");

    // R4: output disable
    drive(0, 1, 1, 0, 0, 11'd5, '0, 0, 1, 0, '0, "R4 output disable");
    // R3: standby with the output gate low
    drive(1, 0, 1, 0, 0, 11'd5, '0, 0, 1, 0, '0, "R3 standby oe low");
    // R3: inhibit attempts a program, nothing written
    drive(1, 0, 0, 1, 0, 11'd300, 8'h00, 0, 1, 0, '0, "R3 inhibit hiz");
    rd(11'd300, "R3 inhibit left word");

    // R7: identification codes
    drive(0, 0, 1, 0, 1, 11'd0, '0, 0, 1, 1, 8'h01, "R7 maker code");
    drive(0, 0, 1, 0, 1, 11'd1, '0, 0, 1, 1, 8'h16, "R7 part code");
    rd(11'd1, "R2 array after id");

    // R9: program during erase is dropped
    drive(1, 1, 1, 0, 0, '0, '0, 1, 0, 0, '0, "erase2");
    drive(0, 1, 0, 1, 0, 11'd7, 8'h00, 0, 0, 0, '0, "R9 prog during busy");
    drive(0, 1, 0, 1, 0, 11'd1500, 8'h00, 0, 0, 0, '0, "R9 prog during busy");
    idle();
    while (erase_busy === 1'b1) idle();
    for (int k = 0; k < DEPTH; k++) model[k] = '1;
    rd(11'd7, "R9 word 7 stays blank");
    rd(11'd1500, "R9 word 1500 stays blank");
    rd(11'd5, "R8 erased programmed word");
    idle();
    idle();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule